// File: doc/BRIEF.md
# Mesh Route and Channel-Class Selector

This block chooses, for one packet header at a time, where the packet leaves the current node of a two-dimensional mesh. The mesh also carries a bypass ring that links every node. The inputs are the node's own coordinates, the packet's destination coordinates, the channel class the packet travels on (adaptive or escape) and a detour count carried in the header. The selector also takes two 4-bit status vectors for the neighbours: one says which neighbour routers are powered, and the other says whether a powered router lies further along the minimal region behind each neighbour. The outputs are the chosen output port, the channel class after this hop and the updated detour count. All outputs are registered one cycle after the header is presented.

An adaptive packet takes a usable minimal direction when one exists, and a powered neighbour is preferred over a gated-off one. When no minimal direction is usable, the packet detours one hop to a powered neighbour and its count rises by one. When the count has reached a programmable limit, or no detour is possible, the packet moves to the escape class and to the ring port. Escape packets stay on the ring port until they reach their destination. At the destination the packet is sent to local ejection, whatever its class.

Encodings used below: the output port is 0 = local, 1 = east (x+1), 2 = west (x-1), 3 = north (y+1), 4 = south (y-1), 5 = ring. The class bit is 1 for escape. In both neighbour vectors, bit 0 = east, bit 1 = west, bit 2 = north and bit 3 = south.

Top module: `route_class_sel`

## Requirements
- R1: During and right after synchronous reset, sel_valid is 0, sel_port is 0, sel_escape is 0 and sel_misses is 0.
- R2: sel_valid equals hdr_valid delayed by one clock. While hdr_valid is 0, sel_port, sel_escape and sel_misses keep their last values.
- R3: When the current coordinates equal the destination, sel_port is 0 (local). The class and the count pass through unchanged, for either class.
- R4: An escape-class header not at its destination gets sel_port 5 (ring). It stays escape and its count is unchanged.
- R5: For an adaptive header, a minimal direction is usable if its bit is set in nbr_powered or in beyond_powered. If any usable minimal direction has its neighbour powered (nbr_powered bit), one of those is chosen over directions that are usable only through beyond_powered. The class stays adaptive and the count is unchanged.
- R6: Among equally preferred minimal directions, the X directions (east/west) win over the Y directions (north/south).
- R7: With no usable minimal direction and hdr_misses below miss_limit, the packet detours to the first powered neighbour that exists in the mesh and is not minimal, checked in the order east, west, north, south. The count is incremented by one and the class stays adaptive.
- R8: With no usable minimal direction, the header moves to escape on port 5 with its count unchanged if either of two conditions holds: hdr_misses is at or above miss_limit, or no detour candidate exists.
- R9: A direction that would leave the mesh edge is never chosen, even if its powered bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A header is presented this cycle |
| here_x | input | XW | Current node X coordinate |
| here_y | input | YW | Current node Y coordinate |
| dest_x | input | XW | Destination X coordinate |
| dest_y | input | YW | Destination Y coordinate |
| hdr_escape | input | 1 | Current class, 1 = escape |
| hdr_misses | input | MW | Detour count from the header |
| miss_limit | input | MW | Programmable detour limit |
| nbr_powered | input | 4 | Neighbour router powered, bits E,W,N,S |
| beyond_powered | input | 4 | Powered router exists past that neighbour on a minimal path |
| sel_valid | output | 1 | Registered decision valid |
| sel_port | output | 3 | Chosen output port code |
| sel_escape | output | 1 | Class after this hop |
| sel_misses | output | MW | Updated detour count |

## Verification
A corrupted decision register shows up on the ports on the clock edge right after the header is taken. It appears as a wrong port code, a class bit that drops from escape back to adaptive, or a count that moves by more than one. The bench therefore compares every decision one cycle after it presents the header. The hold behaviour shows whether stale state leaks while hdr_valid is low. Preference errors only appear when two directions compete, so mixed powered and gated-off neighbour patterns are driven at interior, edge and corner nodes.

// File: rtl/route_class_pkg.sv
package route_class_pkg;
  localparam int unsigned PORT_W = 3;
  localparam logic [PORT_W-1:0] P_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] P_EAST  = 3'd1;
  localparam logic [PORT_W-1:0] P_WEST  = 3'd2;
  localparam logic [PORT_W-1:0] P_NORTH = 3'd3;
  localparam logic [PORT_W-1:0] P_SOUTH = 3'd4;
  localparam logic [PORT_W-1:0] P_RING  = 3'd5;

  typedef enum logic [1:0] {
    K_MIN    = 2'd0,
    K_DETOUR = 2'd1,
    K_FORCE  = 2'd2,
    K_LOCAL  = 2'd3
  } kind_t;
endpackage

// File: rtl/route_geom.sv
module route_geom #(
  parameter int unsigned X_DIM = 4,
  parameter int unsigned Y_DIM = 4,
  localparam int unsigned XW = (X_DIM > 1) ? $clog2(X_DIM) : 1,
  localparam int unsigned YW = (Y_DIM > 1) ? $clog2(Y_DIM) : 1
) (
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  input  logic [XW-1:0] dest_x,
  input  logic [YW-1:0] dest_y,
  output logic          arrived,
  output logic [3:0]    min_dirs,
  output logic [3:0]    on_mesh
);
  localparam logic [XW-1:0] X_LAST = XW'(X_DIM - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(Y_DIM - 1);

  always_comb begin
    arrived     = (here_x == dest_x) && (here_y == dest_y);
    min_dirs[0] = dest_x > here_x;
    min_dirs[1] = dest_x < here_x;
    min_dirs[2] = dest_y > here_y;
    min_dirs[3] = dest_y < here_y;
    on_mesh[0]  = here_x < X_LAST;
    on_mesh[1]  = here_x != '0;
    on_mesh[2]  = here_y < Y_LAST;
    on_mesh[3]  = here_y != '0;
  end
endmodule

// File: rtl/route_pick.sv
module route_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] cand,
  output logic         any,
  output logic [2:0]   code
);
  always_comb begin
    any  = 1'b0;
    code = 3'd0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any  = 1'b1;
        code = 3'(i + 1);
      end
    end
  end
endmodule

// File: rtl/route_class_sel.sv
module route_class_sel
  import route_class_pkg::*;
#(
  parameter int unsigned X_DIM = 4,
  parameter int unsigned Y_DIM = 4,
  parameter int unsigned MW    = 3,
  localparam int unsigned XW = (X_DIM > 1) ? $clog2(X_DIM) : 1,
  localparam int unsigned YW = (Y_DIM > 1) ? $clog2(Y_DIM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hdr_valid,
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  input  logic [XW-1:0] dest_x,
  input  logic [YW-1:0] dest_y,
  input  logic          hdr_escape,
  input  logic [MW-1:0] hdr_misses,
  input  logic [MW-1:0] miss_limit,
  input  logic [3:0]    nbr_powered,
  input  logic [3:0]    beyond_powered,
  output logic          sel_valid,
  output logic [2:0]    sel_port,
  output logic          sel_escape,
  output logic [MW-1:0] sel_misses
);
  logic       arrived;
  logic [3:0] min_dirs, on_mesh;

  route_geom #(.X_DIM(X_DIM), .Y_DIM(Y_DIM)) i_geom (
    .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
    .arrived(arrived), .min_dirs(min_dirs), .on_mesh(on_mesh)
  );

  // Candidate sets: 0 = minimal through powered neighbour,
  // 1 = minimal usable through a powered router further on, 2 = detour.
  localparam int unsigned NSET = 3;
  logic [3:0] cand   [NSET];
  logic       c_any  [NSET];
  logic [2:0] c_code [NSET];

  always_comb begin
    cand[0] = min_dirs & nbr_powered;
    cand[1] = min_dirs & (nbr_powered | beyond_powered);
    cand[2] = on_mesh & ~min_dirs & nbr_powered;
  end

  for (genvar g = 0; g < NSET; g++) begin : g_pick
    route_pick #(.N(4)) i_pick (
      .cand(cand[g]), .any(c_any[g]), .code(c_code[g])
    );
  end

  kind_t         kind;
  logic [2:0]    nxt_port;
  logic          nxt_escape;
  logic [MW-1:0] nxt_misses;

  always_comb begin
    nxt_port   = P_RING;
    nxt_escape = 1'b1;
    nxt_misses = hdr_misses;
    if (arrived) begin
      kind = K_LOCAL;
    end else if (hdr_escape) begin
      kind = K_FORCE;
    end else if (c_any[0] || c_any[1]) begin
      kind = K_MIN;
    end else if ((hdr_misses < miss_limit) && c_any[2]) begin
      kind = K_DETOUR;
    end else begin
      kind = K_FORCE;
    end
    unique case (kind)
      K_LOCAL: begin
        nxt_port   = P_LOCAL;
        nxt_escape = hdr_escape;
      end
      K_MIN: begin
        nxt_port   = c_any[0] ? c_code[0] : c_code[1];
        nxt_escape = 1'b0;
      end
      K_DETOUR: begin
        nxt_port   = c_code[2];
        nxt_escape = 1'b0;
        nxt_misses = hdr_misses + MW'(1);
      end
      default: begin
        nxt_port   = P_RING;
        nxt_escape = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid  <= 1'b0;
      sel_port   <= P_LOCAL;
      sel_escape <= 1'b0;
      sel_misses <= '0;
    end else begin
      sel_valid <= hdr_valid;
      if (hdr_valid) begin
        sel_port   <= nxt_port;
        sel_escape <= nxt_escape;
        sel_misses <= nxt_misses;
      end
    end
  end
endmodule

// File: rtl/route_class_sel_chk.sv
module route_class_sel_chk #(
  parameter int unsigned XW = 2,
  parameter int unsigned YW = 2,
  parameter int unsigned MW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          hdr_valid,
  input logic [XW-1:0] here_x,
  input logic [YW-1:0] here_y,
  input logic [XW-1:0] dest_x,
  input logic [YW-1:0] dest_y,
  input logic          hdr_escape,
  input logic [MW-1:0] hdr_misses,
  input logic [MW-1:0] miss_limit,
  input logic          sel_valid,
  input logic [2:0]    sel_port,
  input logic          sel_escape,
  input logic [MW-1:0] sel_misses
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sel_valid && sel_port == 3'd0 && !sel_escape && sel_misses == '0));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> sel_valid);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !sel_valid);

  assert_arrive_local_R3: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && here_x == dest_x && here_y == dest_y) |=> (sel_port == 3'd0));

  assert_escape_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_escape) |=> (sel_escape && sel_misses == $past(hdr_misses)));

  assert_miss_step_R7: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> (sel_misses == $past(hdr_misses) || sel_misses == $past(hdr_misses) + MW'(1)));

  assert_limit_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_misses >= miss_limit) |=> (sel_misses == $past(hdr_misses)));
endmodule

bind route_class_sel route_class_sel_chk #(.XW(XW), .YW(YW), .MW(MW)) i_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
  .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
  .hdr_escape(hdr_escape), .hdr_misses(hdr_misses), .miss_limit(miss_limit),
  .sel_valid(sel_valid), .sel_port(sel_port), .sel_escape(sel_escape),
  .sel_misses(sel_misses)
);

// File: tb/test_route_class_sel.sv
`timescale 1ns/1ps
module test_route_class_sel;
  localparam int MW = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 1'b0;
  logic [1:0] here_x = '0, here_y = '0, dest_x = '0, dest_y = '0;
  logic hdr_escape = 1'b0;
  logic [MW-1:0] hdr_misses = '0, miss_limit = 3'd2;
  logic [3:0] nbr_powered = '0, beyond_powered = '0;
  logic sel_valid;
  logic [2:0] sel_port;
  logic sel_escape;
  logic [MW-1:0] sel_misses;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  route_class_sel #(.X_DIM(4), .Y_DIM(4), .MW(MW)) i_route_class_sel (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
    .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
    .hdr_escape(hdr_escape), .hdr_misses(hdr_misses), .miss_limit(miss_limit),
    .nbr_powered(nbr_powered), .beyond_powered(beyond_powered),
    .sel_valid(sel_valid), .sel_port(sel_port), .sel_escape(sel_escape),
    .sel_misses(sel_misses)
  );

  task automatic check(input string req, input logic [2:0] p, input logic e, input logic [MW-1:0] m);
    total++;
    if (sel_valid !== 1'b1 || sel_port !== p || sel_escape !== e || sel_misses !== m) begin
      bad++;
      $display("FAIL %s: got v=%0b port=%0d esc=%0b miss=%0d, want v=1 port=%0d esc=%0b miss=%0d",
               req, sel_valid, sel_port, sel_escape, sel_misses, p, e, m);
    end
  endtask

  // Present one header, then sample the registered result mid-cycle.
  task automatic send(input int cx, input int cy, input int dx, input int dy,
                      input logic esc, input int miss, input logic [3:0] np, input logic [3:0] bp);
    @(negedge clk);
    hdr_valid = 1'b1;
    here_x = 2'(cx); here_y = 2'(cy); dest_x = 2'(dx); dest_y = 2'(dy);
    hdr_escape = esc; hdr_misses = MW'(miss);
    nbr_powered = np; beyond_powered = bp;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic t_reset;
    total++;
    if (sel_valid !== 1'b0 || sel_port !== 3'd0 || sel_escape !== 1'b0 || sel_misses !== '0) begin
      bad++;
      $display("FAIL R1: got v=%0b port=%0d esc=%0b miss=%0d, want all 0",
               sel_valid, sel_port, sel_escape, sel_misses);
    end
  endtask

  task automatic t_local;
    send(1, 1, 1, 1, 1'b0, 1, 4'b0000, 4'b0000); check("R3 adaptive", 3'd0, 1'b0, 3'd1);
    send(2, 3, 2, 3, 1'b1, 2, 4'b1111, 4'b0000); check("R3 escape", 3'd0, 1'b1, 3'd2);
  endtask

  task automatic t_escape;
    send(1, 1, 3, 3, 1'b1, 1, 4'b1111, 4'b1111); check("R4", 3'd5, 1'b1, 3'd1);
  endtask

  task automatic t_minimal;
    send(1, 1, 3, 1, 1'b0, 0, 4'b0001, 4'b0000); check("R5 powered east", 3'd1, 1'b0, 3'd0);
    send(1, 1, 3, 1, 1'b0, 0, 4'b0000, 4'b0001); check("R5 beyond east", 3'd1, 1'b0, 3'd0);
    send(1, 1, 3, 3, 1'b0, 1, 4'b0100, 4'b0001); check("R5 powered over beyond", 3'd3, 1'b0, 3'd1);
    send(2, 2, 0, 2, 1'b0, 0, 4'b0010, 4'b0000); check("R5 west", 3'd2, 1'b0, 3'd0);
    send(2, 2, 2, 0, 1'b0, 0, 4'b0000, 4'b1000); check("R5 south", 3'd4, 1'b0, 3'd0);
  endtask

  task automatic t_tie;
    send(1, 1, 3, 3, 1'b0, 0, 4'b0101, 4'b0000); check("R6 powered tie", 3'd1, 1'b0, 3'd0);
    send(1, 1, 3, 3, 1'b0, 0, 4'b0000, 4'b0101); check("R6 beyond tie", 3'd1, 1'b0, 3'd0);
    send(2, 2, 0, 0, 1'b0, 0, 4'b1010, 4'b0000); check("R6 west over south", 3'd2, 1'b0, 3'd0);
  endtask

  task automatic t_detour;
    send(1, 1, 3, 3, 1'b0, 0, 4'b0010, 4'b0000); check("R7 west", 3'd2, 1'b0, 3'd1);
    send(1, 1, 3, 3, 1'b0, 1, 4'b1010, 4'b0000); check("R7 order", 3'd2, 1'b0, 3'd2);
    send(1, 1, 3, 3, 1'b0, 0, 4'b1000, 4'b0000); check("R7 south", 3'd4, 1'b0, 3'd1);
  endtask

  task automatic t_force;
    send(1, 1, 3, 3, 1'b0, 2, 4'b1010, 4'b0000); check("R8 limit", 3'd5, 1'b1, 3'd2);
    send(1, 1, 3, 3, 1'b0, 0, 4'b0000, 4'b0000); check("R8 no candidate", 3'd5, 1'b1, 3'd0);
  endtask

  task automatic t_edge;
    send(0, 0, 0, 3, 1'b0, 0, 4'b1011, 4'b0000); check("R9 corner", 3'd1, 1'b0, 3'd1);
    send(3, 0, 3, 3, 1'b0, 0, 4'b1011, 4'b0000); check("R9 east edge", 3'd2, 1'b0, 3'd1);
    send(0, 0, 0, 3, 1'b0, 0, 4'b1010, 4'b0000); check("R9 no exit", 3'd5, 1'b1, 3'd0);
  endtask

  task automatic t_hold;
    send(1, 1, 3, 1, 1'b0, 0, 4'b0001, 4'b0000);
    check("R2 take", 3'd1, 1'b0, 3'd0);
    @(negedge clk);
    here_x = 2'd3; dest_x = 2'd0; hdr_escape = 1'b1; hdr_misses = 3'd4;
    @(negedge clk);
    total++;
    if (sel_valid !== 1'b0 || sel_port !== 3'd1 || sel_escape !== 1'b0 || sel_misses !== 3'd0) begin
      bad++;
      $display("FAIL R2: got v=%0b port=%0d esc=%0b miss=%0d, want v=0 port=1 esc=0 miss=0",
               sel_valid, sel_port, sel_escape, sel_misses);
    end
  endtask

  initial begin
    #50000;
    bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_local();
    t_escape();
    t_minimal();
    t_tie();
    t_detour();
    t_force();
    t_edge();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule